// File: doc/BRIEF.md
# External Bus Access Stretch Controller

This block sequences one read or write on an external bus and decides how many clock cycles the access occupies. An internal master raises a request carrying a direction, a chip-select index and an emulation flag. The block then drives the matching chip-select line and a read or write strobe for the whole access. At the end it pulses a completion signal. The length comes from one of three rules, picked when the request is accepted:

- a programmed count of extra cycles;
- a handshake with an external wait pin, for chip-selects enabled for it;
- a fixed two-cycle length, for accesses that stand in for port registers.

The external wait pin is asynchronous to the block. It passes through a two-stage synchronizer that is clocked at the rate of the free-running bus clock enable, and the block also drives that enable as an output. The block is a state machine with five states:

- `ST_IDLE`: waits for a request.
- `ST_STRETCH`: counts programmed stretch cycles.
- `ST_WAIT_MIN`: the first of the two forced stretch cycles in wait mode.
- `ST_WAIT_WIN`: the sampling window, repeated while the wait pin is seen asserted.
- `ST_FINAL`: the last cycle of the access, in which `done` is high.

The state transitions are:

- **accept**: `ST_IDLE` moves to `ST_STRETCH`, `ST_WAIT_MIN` or `ST_FINAL` when `req_valid` is high.
- **count**: `ST_STRETCH` loops on itself until its counter reaches one, then moves to `ST_FINAL`.
- **forced**: `ST_WAIT_MIN` always moves to `ST_WAIT_WIN`.
- **extend / release**: `ST_WAIT_WIN` stays in place while the synchronized wait is high, and moves to `ST_FINAL` when it is low.
- **retire**: `ST_FINAL` always returns to `ST_IDLE`.

Top module: `xbus_stretch_ctl`

## Requirements
- R1: While `rst_n` is low, and after its release until a request arrives, `cs_sel` is all zero and `rd_stb`, `wr_stb`, `busy` and `done` are low.
- R2: When the access is neither an emulation access nor in wait mode, it lasts 1 + `stretch_cfg` cycles, so 1 to 8 cycles. `stretch_cfg` is sampled only on the accepting edge, and later changes have no effect on that access.
- R3: When `req_emul` is 1, the access lasts exactly 2 cycles, whatever `stretch_cfg`, `wait_en_mask` and `ext_wait` hold.
- R4: Wait mode applies when bit `req_cs` of `wait_en_mask` is 1 (bit i belongs to chip-select i) and `req_emul` is 0. When that bit is 0, the R2 rule applies even if other mask bits are set.
- R5: In wait mode with `ext_wait` held low, the access lasts 3 cycles: two forced stretch cycles, then the final cycle.
- R6: In wait mode, suppose `ext_wait` is high on H consecutive clock edges starting at the accepting edge, and low afterwards. Then the access lasts 3 + H cycles. The pin reaches the decision through two synchronizer stages.
- R7: During every cycle of an access, `cs_sel` is one-hot, with bit `req_cs` set. `rd_stb` is high when `req_write` was 0 and `wr_stb` is high when it was 1. All of these fall together in the cycle after the final cycle.
- R8: `busy` is high from the cycle after acceptance through the final cycle. `done` is high for exactly one cycle, the final one.
- R9: A request raised while `busy` is high is ignored. A request held high is accepted on the edge that ends the idle cycle following `done`.
- R10: With the default divider of 1, `bus_clk_en` is high on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request from the internal master |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W (2) | Chip-select index of the request |
| req_emul | input | 1 | Access replaces an emulated port register (fixed length) |
| stretch_cfg | input | STR_W (3) | Programmed extra-cycle count |
| wait_en_mask | input | NUM_CS (4) | Per-chip-select enable of the external wait handshake |
| ext_wait | input | 1 | Raw asynchronous external wait pin, active high |
| cs_sel | output | NUM_CS (4) | One-hot chip-select, active high |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| bus_clk_en | output | 1 | Free-running bus-rate clock enable |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties watch, on every cycle, the following:

- `cs_sel` is one-hot exactly while `busy` is high;
- the read and write strobes never overlap;
- `done` lasts one cycle and is followed by idle;
- an access only starts after a request;
- the stretch counter never sits at zero inside a counting state.

The access lengths themselves can only be shown by the bench's scenarios. Those are the programmed count, the two-cycle emulation length, the forced wait minimum and the one-cycle growth per asserted wait sample through the synchronizer. The same holds for ignoring requests and configuration changes during an access, and for back-to-back acceptance.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_STRETCH  = 3'd1,
        ST_WAIT_MIN = 3'd2,
        ST_WAIT_WIN = 3'd3,
        ST_FINAL    = 3'd4
    } xbus_state_e;

endpackage

// File: rtl/xbus_eclk_gen.sv
module xbus_eclk_gen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = rst_n && (cnt_q == '0);

endmodule

// File: rtl/xbus_wait_sync.sv
module xbus_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic synced
);
    logic [STAGES-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (en) begin
            st_q <= {st_q[STAGES-2:0], raw};
        end
    end

    assign synced = st_q[STAGES-1];

endmodule

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode #(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  logic [CS_W-1:0]   idx,
    input  logic              en,
    output logic [NUM_CS-1:0] sel
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign sel[i] = en && (idx == CS_W'(i));
    end

endmodule

// File: rtl/xbus_stretch_ctl.sv
module xbus_stretch_ctl
    import xbus_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int STR_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ECLK_DIV    = 1,
    localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic              req_emul,
    input  logic [STR_W-1:0]  stretch_cfg,
    input  logic [NUM_CS-1:0] wait_en_mask,
    input  logic              ext_wait,
    output logic [NUM_CS-1:0] cs_sel,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              bus_clk_en,
    output logic              busy,
    output logic              done
);
    localparam logic [STR_W-1:0] EMUL_STRETCH = STR_W'(1);

    xbus_state_e      state_q;
    logic [STR_W-1:0] cnt_q;
    logic [CS_W-1:0]  cs_q;
    logic             wr_q;
    logic             wait_seen;
    logic             active;

    // Free-running bus-rate enable; also paces the wait synchronizer
    xbus_eclk_gen #(.DIV(ECLK_DIV)) u_eclk (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (bus_clk_en)
    );

    xbus_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bus_clk_en),
        .raw   (ext_wait),
        .synced(wait_seen)
    );

    xbus_cs_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
        .idx(cs_q),
        .en (active),
        .sel(cs_sel)
    );

    // State register and access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cs_q    <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cs_q <= req_cs;
                        wr_q <= req_write;
                        if (req_emul) begin
                            cnt_q   <= EMUL_STRETCH;
                            state_q <= ST_STRETCH;
                        end else if (wait_en_mask[req_cs]) begin
                            state_q <= ST_WAIT_MIN;
                        end else if (stretch_cfg == '0) begin
                            state_q <= ST_FINAL;
                        end else begin
                            cnt_q   <= stretch_cfg;
                            state_q <= ST_STRETCH;
                        end
                    end
                end
                ST_STRETCH: begin
                    if (cnt_q == EMUL_STRETCH) begin
                        state_q <= ST_FINAL;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_WAIT_MIN: begin
                    state_q <= ST_WAIT_WIN;
                end
                ST_WAIT_WIN: begin
                    if (!wait_seen) begin
                        state_q <= ST_FINAL;
                    end
                end
                ST_FINAL: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        active = (state_q != ST_IDLE);
        busy   = active;
        done   = (state_q == ST_FINAL);
        rd_stb = active && !wr_q;
        wr_stb = active && wr_q;
    end

    AST_CS_ONEHOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(cs_sel) && ((cs_sel != '0) == busy))); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb) && ((rd_stb || wr_stb) == (cs_sel != '0))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8
    AST_DONE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8
    AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R9
    AST_STRETCH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STRETCH) |-> (cnt_q != '0)); // R2

endmodule

// File: tb/tb_xbus_stretch_ctl.sv
module tb_xbus_stretch_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_cs = '0;
    logic       req_emul = 1'b0;
    logic [2:0] stretch_cfg = '0;
    logic [3:0] wait_en_mask = '0;
    logic       ext_wait = 1'b0;
    logic [3:0] cs_sel;
    logic       rd_stb, wr_stb, bus_clk_en, busy, done;

    int n_checks = 0;
    int n_fails  = 0;
    int eclk_low = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xbus_stretch_ctl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cs(req_cs), .req_emul(req_emul), .stretch_cfg(stretch_cfg),
        .wait_en_mask(wait_en_mask), .ext_wait(ext_wait), .cs_sel(cs_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_clk_en(bus_clk_en),
        .busy(busy), .done(done)
    );

    // Vector layout: [0] write, [2:1] cs, [3] emul, [6:4] stretch,
    // [10:7] wait mask, [15:11] wait-high edges, [20:16] expected cycles
    function automatic logic [20:0] mk(input logic w, input logic [1:0] cs,
        input logic em, input logic [2:0] st, input logic [3:0] mask,
        input logic [4:0] hold, input logic [4:0] len);
        return {len, hold, mask, st, em, cs, w};
    endfunction

    localparam int NV = 11;
    localparam logic [20:0] VEC [0:NV-1] = '{
        mk(1'b0, 2'd0, 1'b0, 3'd0, 4'h0, 5'd0,  5'd1),
        mk(1'b1, 2'd1, 1'b0, 3'd3, 4'h0, 5'd0,  5'd4),
        mk(1'b0, 2'd2, 1'b0, 3'd7, 4'h0, 5'd0,  5'd8),
        mk(1'b1, 2'd3, 1'b1, 3'd7, 4'h0, 5'd0,  5'd2),
        mk(1'b0, 2'd1, 1'b1, 3'd5, 4'h2, 5'd4,  5'd2),
        mk(1'b0, 2'd2, 1'b0, 3'd6, 4'h4, 5'd0,  5'd3),
        mk(1'b1, 2'd2, 1'b0, 3'd0, 4'h4, 5'd1,  5'd4),
        mk(1'b0, 2'd0, 1'b0, 3'd1, 4'h1, 5'd5,  5'd8),
        mk(1'b1, 2'd3, 1'b0, 3'd2, 4'h7, 5'd3,  5'd3),
        mk(1'b1, 2'd0, 1'b0, 3'd0, 4'h1, 5'd12, 5'd15),
        mk(1'b0, 2'd3, 1'b0, 3'd1, 4'h8, 5'd0,  5'd3)
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 50000);
            summary();
        end
    end

    always @(negedge clk) if (rst_n && !bus_clk_en) eclk_low++;

    // Runs from a negedge with inputs set; returns cycle count to done and strobe errors
    task automatic run_access(input int hold, input logic [3:0] exp_cs, input logic w,
                              output int len, output int errs);
        len = 0;
        errs = 0;
        ext_wait = (hold != 0);
        req_valid = 1'b1;
        @(posedge clk);
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (n == hold) ext_wait = 1'b0;
            if (cs_sel != exp_cs || rd_stb != !w || wr_stb != w || !busy) errs++;
            if (done) begin
                len = n;
                break;
            end
        end
        ext_wait = 1'b0;
    endtask

    initial begin
        int len, errs;
        string tag;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(cs_sel == 0 && !rd_stb && !wr_stb && !busy && !done, "R1", "outputs in reset",
              {cs_sel, rd_stb, wr_stb, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_sel == 0 && !rd_stb && !wr_stb && !busy && !done, "R1", "idle after reset",
              {cs_sel, rd_stb, wr_stb, busy, done}, 0);

        // Table walk: R2, R3, R4, R5, R6, R7, R8
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            req_write    = v[0];
            req_cs       = v[2:1];
            req_emul     = v[3];
            stretch_cfg  = v[6:4];
            wait_en_mask = v[10:7];
            if (v[3]) tag = "R3";
            else if (v[10:7][v[2:1]]) tag = (v[15:11] == 0) ? "R5" : "R6";
            else tag = (v[10:7] != 0) ? "R4" : "R2";
            run_access(int'(v[15:11]), 4'(1) << v[2:1], v[0], len, errs);
            check(len == int'(v[20:16]), tag, "access length", len, int'(v[20:16]));
            check(errs == 0, "R7", "strobes/chip-select during access", errs, 0);
            @(negedge clk);
            check(!done && !busy && cs_sel == 0 && !rd_stb && !wr_stb, "R8",
                  "single done then idle", {done, busy, cs_sel}, 0);
            @(negedge clk);
        end

        // R9 and R2: request and config changes during an access are ignored
        req_write = 1'b0; req_cs = 2'd0; req_emul = 1'b0;
        stretch_cfg = 3'd4; wait_en_mask = 4'h0;
        ext_wait = 1'b0;
        req_valid = 1'b1;
        @(posedge clk);
        errs = 0; len = 0;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            req_valid = (n == 2);
            if (n == 2) begin
                req_write = 1'b1; req_cs = 2'd3; stretch_cfg = 3'd0; req_emul = 1'b1;
            end
            if (cs_sel != 4'b0001 || !rd_stb || wr_stb) errs++;
            if (done) begin
                len = n;
                break;
            end
        end
        check(len == 5, "R2", "length kept after mid-access config change", len, 5);
        check(errs == 0, "R9", "mid-access request did not alter strobes", errs, 0);
        @(negedge clk);
        check(!busy, "R9", "busy after ignored request", busy, 0);
        @(negedge clk);
        check(!busy && cs_sel == 0, "R9", "ignored request not accepted later", busy, 0);

        // R9: held request, back-to-back acceptance
        req_write = 1'b1; req_cs = 2'd2; req_emul = 1'b0; stretch_cfg = 3'd1;
        req_valid = 1'b1;
        @(posedge clk);
        len = 0;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            if (n == 3) check(!busy, "R9", "idle cycle between accesses", busy, 0);
            if (n == 4) begin
                check(busy && cs_sel == 4'b0100 && wr_stb, "R9", "second access started",
                      {busy, cs_sel}, 5'b10100);
                req_valid = 1'b0;
            end
            if (done && n > 2) begin
                len = n;
                break;
            end
        end
        check(len == 5, "R9", "second done cycle", len, 5);
        @(negedge clk);
        check(!busy && !done, "R8", "idle after second access", {busy, done}, 0);

        // R10: enable runs at full rate
        check(eclk_low == 0, "R10", "cycles with bus_clk_en low", eclk_low, 0);
        summary();
    end

endmodule